// File: doc/BRIEF.md
# Integer Divider with Divide-by-Zero Trap

This unit computes the 32-bit quotient of a dividend and a divisor over many cycles. It works in one of two modes, chosen per operation: unsigned, or two's-complement signed. A caller places the operands and the mode on the inputs and pulses `start_i` while the unit is idle. The quotient appears on `quot_o` in the same cycle that `done_o` pulses high.

The unit uses a restoring shift-and-subtract loop that produces one quotient bit per clock. A final clock applies the sign of the result. A zero divisor bypasses the loop: the operation finishes after a single edge with a zero quotient.

Every accepted operation updates a sticky divide-by-zero status bit. A zero divisor also produces a one-cycle exception request, but only when the global exception enable and the divide-trap configuration enable are both high. When that request fires, the cause output is loaded with a fixed code.

Top module: `int_div_trap`

## Requirements
- R1: While reset is high and in the cycle after it is released, `busy_o`, `done_o`, `exc_req_o` and `dz_flag_o` are 0, and `quot_o` and `exc_cause_o` are all zeros.
- R2: With `signed_i`=0, a nonzero-divisor operation yields floor(dividend/divisor) as unsigned values. `done_o` is high for the one cycle that starts 33 rising edges after the edge that accepted `start_i`.
- R3: With `signed_i`=1, both operands are two's-complement. The quotient is truncated toward zero and is negative exactly when the operand signs differ and the quotient magnitude is nonzero.
- R4: In signed mode, 0x80000000 divided by 0xFFFFFFFF (-1) yields 0x80000000.
- R5: A zero divisor yields `quot_o`=0, and `done_o` is high in the cycle right after the accepting edge, with no iteration performed.
- R6: Accepting a zero-divisor operation sets `dz_flag_o` to 1. The flag keeps that value until a later operation is accepted.
- R7: Accepting an operation with a nonzero divisor clears `dz_flag_o` on the accepting edge.
- R8: `exc_req_o` pulses for one cycle, together with `done_o`, for a zero-divisor operation when both `exc_en_i` and `trap_en_i` were 1 at acceptance. It stays 0 in every other case.
- R9: When `exc_req_o` pulses, `exc_cause_o` holds `CAUSE_CODE` (default 5'd5). It keeps that value until the next exception request.
- R10: A `start_i` pulse while `busy_o`=1 is ignored. It changes neither the quotient nor the completion cycle of the running operation, and it does not change `dz_flag_o` or `exc_req_o`.
- R11: `busy_o` is high from the accepting edge of a nonzero-divisor operation until the edge that raises `done_o`. `done_o` is a single-cycle pulse that is never high together with `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts an operation when the unit is idle |
| signed_i | input | 1 | 1 = signed operands, 0 = unsigned |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor |
| exc_en_i | input | 1 | Global exception enable |
| trap_en_i | input | 1 | Divide-by-zero trap configuration enable |
| busy_o | output | 1 | An iterative division is in progress |
| done_o | output | 1 | One-cycle completion pulse; quotient valid |
| quot_o | output | 32 | Quotient of the last completed operation |
| dz_flag_o | output | 1 | Sticky divide-by-zero status |
| exc_req_o | output | 1 | Divide-by-zero exception request pulse |
| exc_cause_o | output | 5 | Exception cause code |

## Verification
The assertions assume that operands, mode and both enables are stable at the rising edge that samples `start_i`. They also assume that reset is held for at least one edge before the first operation. The bench changes every input only at falling edges and holds reset for several cycles. It deliberately pulses `start_i` while the unit is busy, including with a zero divisor and both enables high, so the ignore path must hold without any help from the inputs.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

    localparam int unsigned XLEN   = 32;
    localparam int unsigned STEP_W = $clog2(XLEN);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ITER,
        PH_FIX
    } phase_e;

    typedef struct packed {
        logic [XLEN-1:0] num_mag;
        logic [XLEN-1:0] den_mag;
        logic            flip;
        logic            den_zero;
    } div_req_t;

    typedef struct packed {
        logic [XLEN-1:0] rem;
        logic [XLEN-1:0] quo;
    } iter_t;

    function automatic logic [XLEN-1:0] magnitude(input logic [XLEN-1:0] v,
                                                  input logic as_signed);
        return (as_signed && v[XLEN-1]) ? XLEN'(~v + 1'b1) : v;
    endfunction

    function automatic logic [XLEN-1:0] negate(input logic [XLEN-1:0] v);
        return XLEN'(~v + 1'b1);
    endfunction

    function automatic iter_t restore_step(input iter_t cur,
                                           input logic [XLEN-1:0] den);
        logic [XLEN:0]   shifted;
        logic [XLEN+1:0] diff;
        iter_t           nxt;
        shifted = {cur.rem, cur.quo[XLEN-1]};
        diff    = {1'b0, shifted} - {2'b00, den};
        if (!diff[XLEN+1]) begin
            nxt.rem = diff[XLEN-1:0];
            nxt.quo = {cur.quo[XLEN-2:0], 1'b1};
        end else begin
            nxt.rem = shifted[XLEN-1:0];
            nxt.quo = {cur.quo[XLEN-2:0], 1'b0};
        end
        return nxt;
    endfunction

endpackage

// File: rtl/idiv_prep.sv
module idiv_prep
    import idiv_pkg::*;
(
    input  logic [XLEN-1:0] num,
    input  logic [XLEN-1:0] den,
    input  logic            is_signed,
    output div_req_t        req
);
    always_comb begin
        req.num_mag  = magnitude(num, is_signed);
        req.den_mag  = magnitude(den, is_signed);
        req.flip     = is_signed & (num[XLEN-1] ^ den[XLEN-1]);
        req.den_zero = (den == '0);
    end
endmodule

// File: rtl/idiv_core.sv
module idiv_core
    import idiv_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            launch,
    input  div_req_t        req,
    output logic            busy,
    output logic            fin,
    output logic [XLEN-1:0] quot
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(XLEN - 1);

    phase_e            phase_q;
    logic [STEP_W-1:0] step_q;
    iter_t             work_q;
    logic [XLEN-1:0]   den_q;
    logic              flip_q;
    logic [XLEN-1:0]   quot_q;
    logic              fin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            step_q  <= '0;
            work_q  <= '0;
            den_q   <= '0;
            flip_q  <= 1'b0;
            quot_q  <= '0;
            fin_q   <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (launch) begin
                        if (req.den_zero) begin
                            quot_q <= '0;
                            fin_q  <= 1'b1;
                        end else begin
                            work_q  <= '{rem: '0, quo: req.num_mag};
                            den_q   <= req.den_mag;
                            flip_q  <= req.flip;
                            step_q  <= '0;
                            phase_q <= PH_ITER;
                        end
                    end
                end
                PH_ITER: begin
                    work_q <= restore_step(work_q, den_q);
                    step_q <= step_q + 1'b1;
                    if (step_q == LAST_STEP) phase_q <= PH_FIX;
                end
                PH_FIX: begin
                    quot_q  <= flip_q ? negate(work_q.quo) : work_q.quo;
                    fin_q   <= 1'b1;
                    phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy = (phase_q != PH_IDLE);
    assign fin  = fin_q;
    assign quot = quot_q;

    // R2: the loop runs its full count before moving on
    p_iter_progress_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ITER && step_q != LAST_STEP) |=> (phase_q == PH_ITER));

    // R11: the sign fix-up cycle is always followed by completion
    p_fix_completes_r11: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FIX) |=> (fin_q && phase_q == PH_IDLE));
endmodule

// File: rtl/idiv_trap.sv
module idiv_trap #(
    parameter int unsigned          CAUSE_W    = 5,
    parameter logic [CAUSE_W-1:0]   CAUSE_CODE = CAUSE_W'(5)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               zero_launch,
    input  logic               nz_launch,
    input  logic               glob_en,
    input  logic               cfg_en,
    output logic               dz_flag,
    output logic               exc_req,
    output logic [CAUSE_W-1:0] cause
);
    logic               dz_q;
    logic               exc_q;
    logic [CAUSE_W-1:0] cause_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dz_q    <= 1'b0;
            exc_q   <= 1'b0;
            cause_q <= '0;
        end else begin
            exc_q <= 1'b0;
            if (zero_launch) begin
                dz_q <= 1'b1;
                if (glob_en && cfg_en) begin
                    exc_q   <= 1'b1;
                    cause_q <= CAUSE_CODE;
                end
            end else if (nz_launch) begin
                dz_q <= 1'b0;
            end
        end
    end

    assign dz_flag = dz_q;
    assign exc_req = exc_q;
    assign cause   = cause_q;

    // R9: the cause code only moves when a request is raised
    p_cause_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !exc_q |-> $stable(cause_q));

    // R8: a request never lasts two cycles
    p_exc_single_r8: assert property (@(posedge clk) disable iff (rst)
        exc_q |=> !exc_q);
endmodule

// File: rtl/int_div_trap.sv
module int_div_trap
    import idiv_pkg::*;
#(
    parameter int unsigned        CAUSE_W    = 5,
    parameter logic [CAUSE_W-1:0] CAUSE_CODE = CAUSE_W'(5)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               signed_i,
    input  logic [XLEN-1:0]    dividend_i,
    input  logic [XLEN-1:0]    divisor_i,
    input  logic               exc_en_i,
    input  logic               trap_en_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [XLEN-1:0]    quot_o,
    output logic               dz_flag_o,
    output logic               exc_req_o,
    output logic [CAUSE_W-1:0] exc_cause_o
);
    div_req_t req;
    logic     accept;

    idiv_prep u_prep (
        .num       (dividend_i),
        .den       (divisor_i),
        .is_signed (signed_i),
        .req       (req)
    );

    assign accept = start_i && !busy_o;

    idiv_core u_core (
        .clk    (clk),
        .rst    (rst),
        .launch (accept),
        .req    (req),
        .busy   (busy_o),
        .fin    (done_o),
        .quot   (quot_o)
    );

    idiv_trap #(
        .CAUSE_W    (CAUSE_W),
        .CAUSE_CODE (CAUSE_CODE)
    ) u_trap (
        .clk         (clk),
        .rst         (rst),
        .zero_launch (accept && req.den_zero),
        .nz_launch   (accept && !req.den_zero),
        .glob_en     (exc_en_i),
        .cfg_en      (trap_en_i),
        .dz_flag     (dz_flag_o),
        .exc_req     (exc_req_o),
        .cause       (exc_cause_o)
    );

    // R8: a trap request coincides with a zero-result completion
    p_exc_with_done_r8: assert property (@(posedge clk) disable iff (rst)
        exc_req_o |-> (done_o && dz_flag_o && quot_o == '0));

    // R6: the status bit rises only alongside a zero-divisor completion
    p_dz_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(dz_flag_o) |-> (done_o && quot_o == '0));

    // R7: the status bit falls only when an iterative operation begins
    p_dz_fall_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(dz_flag_o) |-> busy_o);

    // R10: the visible quotient stays put while a division runs
    p_quot_hold_r10: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (done_o || $stable(quot_o)));

    // R11: completion never overlaps busy
    p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
endmodule

// File: tb/test_int_div_trap.sv
module test_int_div_trap;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        signed_i = 1'b0;
    logic [31:0] dividend_i = '0;
    logic [31:0] divisor_i = '0;
    logic        exc_en_i = 1'b0;
    logic        trap_en_i = 1'b0;
    logic        busy_o, done_o, dz_flag_o, exc_req_o;
    logic [31:0] quot_o;
    logic [4:0]  exc_cause_o;

    always #2 clk = ~clk;

    int_div_trap i_int_div_trap (
        .clk (clk), .rst (rst), .start_i (start_i), .signed_i (signed_i),
        .dividend_i (dividend_i), .divisor_i (divisor_i),
        .exc_en_i (exc_en_i), .trap_en_i (trap_en_i),
        .busy_o (busy_o), .done_o (done_o), .quot_o (quot_o),
        .dz_flag_o (dz_flag_o), .exc_req_o (exc_req_o), .exc_cause_o (exc_cause_o)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    cmp_on = 1'b0;
    bit    finished = 1'b0;
    string cur_tag = "R2";

    function automatic logic [31:0] ref_q(input logic [31:0] a, input logic [31:0] b,
                                          input logic s);
        if (b == 0) return 32'h0;
        if (!s) return a / b;
        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h8000_0000;
        return $signed(a) / $signed(b);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    logic        m_busy, m_done, m_dz, m_exc;
    logic [31:0] m_quot, m_res;
    logic [4:0]  m_cause;
    int          m_cnt;

    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 0; m_done <= 0; m_dz <= 0; m_exc <= 0;
            m_quot <= 0; m_res <= 0; m_cause <= 0; m_cnt <= 0;
        end else begin
            m_done <= 0;
            m_exc  <= 0;
            if (m_busy) begin
                if (m_cnt == 1) begin
                    m_busy <= 0;
                    m_done <= 1;
                    m_quot <= m_res;
                end
                m_cnt <= m_cnt - 1;
            end else if (start_i) begin
                if (divisor_i == 0) begin
                    m_done <= 1;
                    m_quot <= 0;
                    m_dz   <= 1;
                    if (exc_en_i && trap_en_i) begin
                        m_exc   <= 1;
                        m_cause <= 5'd5;
                    end
                end else begin
                    m_dz   <= 0;
                    m_busy <= 1;
                    m_cnt  <= 33;
                    m_res  <= ref_q(dividend_i, divisor_i, signed_i);
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(quot_o == m_quot, cur_tag, quot_o, m_quot);
            chk(busy_o == m_busy, "R11 busy", 32'(busy_o), 32'(m_busy));
            chk(done_o == m_done, "R11 done", 32'(done_o), 32'(m_done));
            chk(dz_flag_o == m_dz, "R6 R7 dz", 32'(dz_flag_o), 32'(m_dz));
            chk(exc_req_o == m_exc, "R8 exc", 32'(exc_req_o), 32'(m_exc));
            chk(exc_cause_o == m_cause, "R9 cause", 32'(exc_cause_o), 32'(m_cause));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic do_op(input logic [31:0] a, input logic [31:0] b, input logic s,
                         input logic ee, input logic ce, input string tag);
        logic [31:0] exp;
        int          n;
        exp = ref_q(a, b, s);
        @(negedge clk);
        cur_tag    = tag;
        dividend_i = a; divisor_i = b; signed_i = s;
        exc_en_i   = ee; trap_en_i = ce;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (!done_o && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(done_o == 1'b1 && quot_o == exp, tag, quot_o, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset values
        chk({busy_o, done_o, exc_req_o, dz_flag_o} == 4'b0, "R1 flags",
            32'({busy_o, done_o, exc_req_o, dz_flag_o}), 32'h0);
        chk(quot_o == 0 && exc_cause_o == 0, "R1 data", quot_o, 32'h0);
        cmp_on = 1'b1;

        // R2: unsigned
        do_op(32'd100, 32'd7, 0, 0, 0, "R2 100/7");
        do_op(32'hFFFF_FFFF, 32'd1, 0, 0, 0, "R2 max/1");
        do_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, "R2 max/max");
        do_op(32'd5, 32'd10, 0, 0, 0, "R2 small/large");
        do_op(32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 0, "R2 unsigned no sign");

        // R3: signed
        do_op(-32'sd100, 32'd7, 1, 0, 0, "R3 -100/7");
        do_op(32'd100, -32'sd7, 1, 0, 0, "R3 100/-7");
        do_op(-32'sd100, -32'sd7, 1, 0, 0, "R3 -100/-7");
        do_op(32'd7, -32'sd1, 1, 0, 0, "R3 7/-1");
        do_op(-32'sd3, 32'd5, 1, 0, 0, "R3 -3/5");

        // R4: most negative wrap
        do_op(32'h8000_0000, 32'hFFFF_FFFF, 1, 0, 0, "R4 min/-1");
        do_op(32'h8000_0000, 32'd1, 1, 0, 0, "R4 min/1");

        // R5 R6 R8: zero divisor under each enable pair
        do_op(32'd55, 32'd0, 0, 0, 0, "R5 zero ee0 ce0");
        chk(dz_flag_o && !exc_req_o, "R6 set, R8 no req", 32'({dz_flag_o, exc_req_o}), 32'b10);
        do_op(32'd55, 32'd0, 1, 1, 0, "R5 zero ee1 ce0");
        chk(!exc_req_o, "R8 global only", 32'(exc_req_o), 32'h0);
        do_op(32'd55, 32'd0, 0, 0, 1, "R5 zero ee0 ce1");
        chk(!exc_req_o, "R8 config only", 32'(exc_req_o), 32'h0);
        do_op(32'd55, 32'd0, 1, 1, 1, "R5 zero both");
        chk(exc_req_o && exc_cause_o == 5'd5, "R8 R9 raised", 32'(exc_cause_o), 32'd5);

        // R7: nonzero clears flag; cause kept
        do_op(32'd9, 32'd3, 0, 1, 1, "R7 clear");
        chk(!dz_flag_o && exc_cause_o == 5'd5, "R7 R9 after clear",
            32'({dz_flag_o, exc_cause_o}), 32'd5);

        // R10: start while busy is ignored
        @(negedge clk);
        cur_tag = "R10 running";
        dividend_i = 32'd1000; divisor_i = 32'd3; signed_i = 0;
        exc_en_i = 0; trap_en_i = 0; start_i = 1;
        @(negedge clk);
        start_i = 0;
        repeat (3) @(negedge clk);
        dividend_i = 32'd9; divisor_i = 32'd0; exc_en_i = 1; trap_en_i = 1; start_i = 1;
        @(negedge clk);
        start_i = 0;
        begin
            int n = 0;
            while (!done_o && n < 100) begin
                @(negedge clk);
                n++;
            end
            chk(done_o && quot_o == 32'd333, "R10 quotient", quot_o, 32'd333);
            chk(!dz_flag_o && !exc_req_o, "R10 status", 32'({dz_flag_o, exc_req_o}), 32'h0);
        end

        // mixed operands
        for (int i = 0; i < 40; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = (i % 7 == 3) ? 32'h0 : ($urandom >> (i % 29));
            do_op(a, b, i[0], i[1], i[2], (b == 0) ? "R5 mixed" : (i[0] ? "R3 mixed" : "R2 mixed"));
        end

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule